// File: doc/BRIEF.md
# Supply Margining Servo Controller

This block is the digital loop that moves a power converter's output to a programmed margin level and keeps it there. It compares a target code against the latest sample from an external ADC that measures the supply. From that comparison it steps an up/down counter whose value drives an 8-bit DAC, and the DAC feeds the converter's trim input. There are two targets, one for margin-high and one for margin-low. The active request picks which target applies.

A request can come from two active-high pins or from two command bits, which would normally sit in a register. The rules for combining them are:

- Conflicting requests are treated as no request.
- A single asserted pin overrides the command bits.

While a request is active, the trim-enable output is high. When no request is active, trim-enable is low, so the trim pin floats and the converter returns to its nominal set point.

The counter moves at most one step for each ADC-valid strobe. When the sample equals the target, the counter freezes and a ready output is raised. The polarity of the ready output is selectable. A limit flag reports that the counter ran into either end of its range before the target was reached.

Top module: `margin_servo`

## Requirements
- R1: The up request (value 1) uses `hiTarget`. The down request (value 2) uses `loTarget`.
- R2: `trimEnable` rises on the first clock edge at which a valid request is present. It falls on the first edge at which no valid request is present.
- R3: On the edge where margining starts, or where the request switches direction, `dacCode` is loaded with `startCode`.
- R4: On an ADC-valid strobe where the sample is below the target, the code increments when `trimInvert`=0 and decrements when `trimInvert`=1. A sample above the target moves the code the opposite way.
- R5: On an ADC-valid strobe where the sample equals the target, the loop locks. From then on the code is frozen until the request ends or changes, and ready is asserted from the next cycle.
- R6: The code saturates at 0 and at 255 and never wraps. A step that is blocked at either end sets `atLimit`. `atLimit` is cleared when margining starts or ends.
- R7: The code changes only on a cycle with `adcValid` high, apart from the preload.
- R8: `readyOut` equals lock when `readyActiveLow`=0, and the inverse of lock when `readyActiveLow`=1.
- R9: When both pins are high, there is no margining. When both command bits are high and no pin is asserted, there is no margining.
- R10: When exactly one pin is high, that pin sets the direction and the command bits are ignored.
- R11: When the request ends, trim-enable drops, lock and limit clear, and ready returns to its inactive level one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinUp | input | 1 | Margin-up request pin, active high |
| pinDown | input | 1 | Margin-down request pin, active high |
| cmdUp | input | 1 | Margin-up command bit |
| cmdDown | input | 1 | Margin-down command bit |
| hiTarget | input | 10 | Target ADC code for margin-high |
| loTarget | input | 10 | Target ADC code for margin-low |
| startCode | input | 8 | Code loaded into the counter when margining starts |
| trimInvert | input | 1 | 1 when a higher DAC code lowers the supply |
| readyActiveLow | input | 1 | Selects the active-low polarity for ready |
| adcSample | input | 10 | Latest ADC reading of the supply |
| adcValid | input | 1 | One-cycle strobe marking a new sample |
| dacCode | output | 8 | Code driven to the trim DAC |
| trimEnable | output | 1 | Drives the trim pin when high; it floats when low |
| readyOut | output | 1 | Set-point-reached flag, with the selected polarity |
| atLimit | output | 1 | Counter hit 0 or 255 before reaching the target |

## Verification
The bench steers a simple plant model, in both trim polarities, onto each target. It checks that the code lands on exactly the expected value. A design with the step direction reversed would run away to a rail and raise the limit flag instead of locking.

Targets out of reach push the counter into both rails. A design that wraps would jump from 255 to 0.

The bench holds samples back with no valid strobe. A design that steps on every cycle would overshoot.

Conflicting pins and conflicting command bits are mixed with a single pin over a contrary command. A design that resolves these wrongly would drive the trim pin when it should float, or chase the wrong target.

// File: rtl/margin_servo_pkg.sv
package margin_servo_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2
  } modeT;

  typedef struct packed {
    logic preload;
    logic inc;
    logic dec;
  } stepCmdT;

endpackage

// File: rtl/margin_servo_ctrl.sv
module margin_servo_ctrl
  import margin_servo_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinUp,
  input  logic             pinDown,
  input  logic             cmdUp,
  input  logic             cmdDown,
  input  logic [ADC_W-1:0] hiTarget,
  input  logic [ADC_W-1:0] loTarget,
  input  logic             trimInvert,
  input  logic [ADC_W-1:0] adcSample,
  input  logic             adcValid,
  input  logic             codeAtMax,
  input  logic             codeAtMin,
  output stepCmdT          stepCmd,
  output modeT             mode,
  output logic             locked,
  output logic             limitHit
);

  modeT             reqMode;
  logic [ADC_W-1:0] target;
  logic             evaluate;
  logic             match;
  logic             needInc;
  logic             blocked;
  logic             modeChange;

  // Request resolution: a single pin wins; conflicts mean no margining.
  always_comb begin
    if (pinUp ^ pinDown)
      reqMode = pinUp ? MODE_UP : MODE_DOWN;
    else if (!pinUp && !pinDown && (cmdUp ^ cmdDown))
      reqMode = cmdUp ? MODE_UP : MODE_DOWN;
    else
      reqMode = MODE_IDLE;
  end

  assign modeChange = (reqMode != mode);
  assign target     = (mode == MODE_UP) ? hiTarget : loTarget;
  assign match      = (adcSample == target);
  assign needInc    = (adcSample < target) ^ trimInvert;
  assign blocked    = needInc ? codeAtMax : codeAtMin;
  assign evaluate   = (mode != MODE_IDLE) && !modeChange && !locked && adcValid;

  always_comb begin
    stepCmd.preload = modeChange && (reqMode != MODE_IDLE);
    stepCmd.inc     = evaluate && !match && needInc  && !codeAtMax;
    stepCmd.dec     = evaluate && !match && !needInc && !codeAtMin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      locked   <= 1'b0;
      limitHit <= 1'b0;
    end else begin
      mode <= reqMode;
      if (modeChange) begin
        locked   <= 1'b0;
        limitHit <= 1'b0;
      end else begin
        if (evaluate && match)
          locked <= 1'b1;
        if (evaluate && !match && blocked)
          limitHit <= 1'b1;
      end
    end
  end

  // R1: while margining, only the up mode and the down mode can be held.
  p_mode_legal_r1 : assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd3);

  // R6: limit is only ever raised while a request is active.
  p_limit_active_r6 : assert property (@(posedge clk) disable iff (!rstN)
    limitHit |-> (mode != MODE_IDLE));

endmodule

// File: rtl/margin_servo_dp.sv
module margin_servo_dp
  import margin_servo_pkg::*;
#(
  parameter int DAC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmdT          stepCmd,
  input  logic [DAC_W-1:0] startCode,
  output logic [DAC_W-1:0] dacCode,
  output logic             codeAtMax,
  output logic             codeAtMin
);

  localparam logic [DAC_W-1:0] CODE_MAX = '1;
  localparam logic [DAC_W-1:0] CODE_MIN = '0;

  assign codeAtMax = (dacCode == CODE_MAX);
  assign codeAtMin = (dacCode == CODE_MIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dacCode <= CODE_MIN;
    else if (stepCmd.preload)
      dacCode <= startCode;
    else if (stepCmd.inc)
      dacCode <= dacCode + DAC_W'(1);
    else if (stepCmd.dec)
      dacCode <= dacCode - DAC_W'(1);
  end

  // R4: the counter moves by at most one code per cycle unless preloaded.
  p_single_step_r4 : assert property (@(posedge clk) disable iff (!rstN)
    !stepCmd.preload |=> (dacCode == $past(dacCode)) ||
                         (dacCode == $past(dacCode) + DAC_W'(1)) ||
                         (dacCode == $past(dacCode) - DAC_W'(1)));

  // R6: no wrap from the top rail to the bottom rail.
  p_no_wrap_hi_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (dacCode == CODE_MAX && !stepCmd.preload) |=> dacCode != CODE_MIN);

  // R6: no wrap from the bottom rail to the top rail.
  p_no_wrap_lo_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (dacCode == CODE_MIN && !stepCmd.preload) |=> dacCode != CODE_MAX);

endmodule

// File: rtl/margin_servo.sv
module margin_servo
  import margin_servo_pkg::*;
#(
  parameter int ADC_W = 10,
  parameter int DAC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinUp,
  input  logic             pinDown,
  input  logic             cmdUp,
  input  logic             cmdDown,
  input  logic [ADC_W-1:0] hiTarget,
  input  logic [ADC_W-1:0] loTarget,
  input  logic [DAC_W-1:0] startCode,
  input  logic             trimInvert,
  input  logic             readyActiveLow,
  input  logic [ADC_W-1:0] adcSample,
  input  logic             adcValid,
  output logic [DAC_W-1:0] dacCode,
  output logic             trimEnable,
  output logic             readyOut,
  output logic             atLimit
);

  stepCmdT stepCmd;
  modeT    mode;
  logic    locked;
  logic    limitHit;
  logic    codeAtMax;
  logic    codeAtMin;

  margin_servo_ctrl #(.ADC_W(ADC_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinUp     (pinUp),
    .pinDown   (pinDown),
    .cmdUp     (cmdUp),
    .cmdDown   (cmdDown),
    .hiTarget  (hiTarget),
    .loTarget  (loTarget),
    .trimInvert(trimInvert),
    .adcSample (adcSample),
    .adcValid  (adcValid),
    .codeAtMax (codeAtMax),
    .codeAtMin (codeAtMin),
    .stepCmd   (stepCmd),
    .mode      (mode),
    .locked    (locked),
    .limitHit  (limitHit)
  );

  margin_servo_dp #(.DAC_W(DAC_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stepCmd  (stepCmd),
    .startCode(startCode),
    .dacCode  (dacCode),
    .codeAtMax(codeAtMax),
    .codeAtMin(codeAtMin)
  );

  assign trimEnable = (mode != MODE_IDLE);
  assign readyOut   = locked ^ readyActiveLow;
  assign atLimit    = limitHit;

  // R9: both pins high leaves the trim output floating.
  p_both_pins_float_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (pinUp && pinDown) |=> !trimEnable);

  // R7: without a valid strobe the code holds, apart from a preload.
  p_step_needs_valid_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (!adcValid && !stepCmd.preload) |=> $stable(dacCode));

  // R5: once locked the code is frozen unless the loop restarts.
  p_hold_locked_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (locked && !stepCmd.preload) |=> $stable(dacCode));

  // R11: lock never persists without an active trim drive.
  p_lock_needs_enable_r11 : assert property (@(posedge clk) disable iff (!rstN)
    locked |-> trimEnable);

endmodule

// File: tb/margin_servo_tb_top.sv
module margin_servo_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinUp = 0, pinDown = 0, cmdUp = 0, cmdDown = 0;
  logic [9:0] hiTarget = 0, loTarget = 0;
  logic [7:0] startCode = 8'd128;
  logic       trimInvert = 0, readyActiveLow = 0;
  logic [9:0] adcSample = 0;
  logic       adcValid = 0;
  logic [7:0] dacCode;
  logic       trimEnable, readyOut, atLimit;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench reference state
  int mMode = 0;
  int mCode = 0;
  bit mLock = 0;
  bit mLimit = 0;
  int plantMode = 0; // 0 random, 1 rising plant, 2 falling plant
  int validDiv = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  margin_servo dut_i (
    .clk(clk), .rstN(rstN), .pinUp(pinUp), .pinDown(pinDown),
    .cmdUp(cmdUp), .cmdDown(cmdDown), .hiTarget(hiTarget), .loTarget(loTarget),
    .startCode(startCode), .trimInvert(trimInvert), .readyActiveLow(readyActiveLow),
    .adcSample(adcSample), .adcValid(adcValid), .dacCode(dacCode),
    .trimEnable(trimEnable), .readyOut(readyOut), .atLimit(atLimit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int reqOf(bit pu, bit pd, bit cu, bit cd);
    if (pu ^ pd) return pu ? 1 : 2;
    if (!pu && !pd && (cu ^ cd)) return cu ? 1 : 2;
    return 0;
  endfunction

  function automatic int plantOf(int mode, int code);
    if (mode == 1) return 100 + code;
    return 400 - code;
  endfunction

  task automatic modelStep();
    int r;
    int tgt;
    bit goUp;
    r = reqOf(pinUp, pinDown, cmdUp, cmdDown);
    if (r != mMode) begin
      mMode = r; mLock = 0; mLimit = 0;
      if (r != 0) mCode = startCode;
    end else if (mMode != 0 && !mLock && adcValid) begin
      tgt = (mMode == 1) ? hiTarget : loTarget;
      if (adcSample == tgt) mLock = 1;
      else begin
        goUp = (adcSample < tgt) ^ trimInvert;
        if (goUp) begin
          if (mCode == 255) mLimit = 1; else mCode++;
        end else begin
          if (mCode == 0) mLimit = 1; else mCode--;
        end
      end
    end
  endtask

  task automatic compareAll();
    check("R2 trimEnable", trimEnable, mMode != 0);
    check("R4 dacCode", dacCode, mCode);
    check("R5 readyOut", readyOut, int'(mLock ^ readyActiveLow));
    check("R6 atLimit", atLimit, mLimit);
  endtask

  // One cycle: inputs are stable from the previous negedge; compare at negedge.
  task automatic tick();
    if (plantMode != 0) adcSample = 10'(plantOf(plantMode, dacCode));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(int n, bit strobe);
    for (int i = 0; i < n; i++) begin
      adcValid = strobe && (i % validDiv == 0);
      tick();
    end
    adcValid = 0;
  endtask

  task automatic idleAll();
    pinUp = 0; pinDown = 0; cmdUp = 0; cmdDown = 0;
    run(2, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    int rv;
    seed = 32'h5eed_1234;
    rv = $urandom(seed);
    repeat (3) @(negedge clk);
    check("R2 reset trimEnable", trimEnable, 0);
    check("R8 reset ready", readyOut, 0);
    check("R6 reset limit", atLimit, 0);
    check("R3 reset dac", dacCode, 0);
    rstN = 1;
    @(negedge clk);

    // R1/R3: up pin, rising plant, hi target 250 -> code 150
    hiTarget = 10'd250; loTarget = 10'd190; startCode = 8'd128;
    plantMode = 1; pinUp = 1;
    run(1, 0);
    check("R3 preload", dacCode, 128);
    check("R2 enable rises", trimEnable, 1);
    run(80, 1);
    check("R1 hi target lock code", dacCode, 150);
    check("R5 ready at lock", readyOut, 1);
    // R7: samples changing with no strobe
    plantMode = 0; adcSample = 10'd5;
    run(5, 0);
    check("R7 no step without valid", dacCode, 150);
    // R8: polarity
    readyActiveLow = 1;
    run(1, 0);
    check("R8 active-low ready", readyOut, 0);
    readyActiveLow = 0;
    // R11: release
    pinUp = 0;
    run(1, 0);
    check("R11 enable drops", trimEnable, 0);
    check("R11 ready inactive", readyOut, 0);

    // R4: inverted trim, command down, falling plant, lo 300 -> code 100
    trimInvert = 1; plantMode = 2; loTarget = 10'd300; cmdDown = 1;
    run(1, 0);
    adcValid = 1; tick(); adcValid = 0;
    check("R4 inverted step direction", dacCode, 127);
    run(80, 1);
    check("R1 lo target lock code", dacCode, 100);

    // R9: conflicting pins / commands
    pinUp = 1; pinDown = 1;
    run(2, 1);
    check("R9 both pins float", trimEnable, 0);
    pinUp = 0; pinDown = 0; cmdUp = 1; cmdDown = 1;
    run(2, 1);
    check("R9 both cmds float", trimEnable, 0);

    // R10: single pin beats contrary command
    trimInvert = 0; plantMode = 1; cmdDown = 0; cmdUp = 1; pinDown = 1;
    loTarget = 10'd190;
    run(80, 1);
    check("R10 pin overrides cmd", dacCode, 90);
    idleAll();

    // R6: high rail
    hiTarget = 10'd1000; pinUp = 1;
    run(300, 1);
    check("R6 top rail", dacCode, 255);
    check("R6 limit set", atLimit, 1);
    pinUp = 0; run(1, 0);
    check("R6 limit clears", atLimit, 0);
    // R6: low rail, inverted falling plant cannot reach 1000
    trimInvert = 1; plantMode = 2; pinDown = 1; loTarget = 10'd1000;
    run(300, 1);
    check("R6 bottom rail", dacCode, 0);
    check("R6 limit low", atLimit, 1);
    idleAll();

    // random phase
    plantMode = 0; validDiv = 1;
    for (int i = 0; i < 3000; i++) begin
      rv = $urandom();
      if (i % 40 == 0) begin
        pinUp = rv[0] & rv[1]; pinDown = rv[2] & rv[3];
        cmdUp = rv[4]; cmdDown = rv[5] & rv[6];
        trimInvert = rv[7]; readyActiveLow = rv[8];
        hiTarget = 10'($urandom_range(0, 1023));
        loTarget = 10'($urandom_range(0, 1023));
        startCode = 8'($urandom_range(0, 255));
      end
      adcValid = rv[9] | rv[10];
      adcSample = rv[11] ? 10'($urandom_range(0, 1023))
                         : ((mMode == 1) ? hiTarget : loTarget);
      tick();
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule